// File: doc/BRIEF.md
# Condition code evaluator

This block decides whether a conditionally executed instruction is allowed to run. It takes the 4-bit condition field of the instruction and the four status flags (negative, zero, carry, overflow) and returns a single pass bit. Sixteen condition codes are decoded. They cover single-flag tests, unsigned and signed magnitude comparisons, an unconditional code and a code that never passes.

A small add/subtract flag generator sits beside the decoder. It forms a sum one bit wider than the data path and derives the four flags from it. A caller can run an operation, feed the resulting flags back into the decoder and test a condition on them. The unit is purely combinational. Decoding of the instruction word and writes to the status register are handled elsewhere.

Top module: `cond_unit`

## Requirements
- R1: Codes 0 to 7 pass on, in order: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R2: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R3: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R4: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R5: Code 14 always passes. Code 15 never passes, whatever the flags.
- R6: Both flag vectors (`flags_i` and `flags_o`) are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. This matches the top four bits of the status word.
- R7: With `sub_i`=0, the unit forms op_a + op_b + carry_i at DATA_W+1 bits. C is the top bit of that sum, N is bit DATA_W-1, and Z=1 exactly when the low DATA_W bits are all zero.
- R8: With `sub_i`=1, the unit forms op_a + ~op_b + 1 and ignores `carry_i`. C=1 means no borrow occurred, so C=1 when op_a >= op_b unsigned.
- R9: For an addition, V=1 exactly when both addends have the same sign and the result sign differs from it. A subtraction uses the inverted second operand as the addend.
- R10: `res_o` equals the low DATA_W bits of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_i | input | 4 | Condition code to evaluate |
| flags_i | input | 4 | Flags {N,Z,C,V} used by the decoder |
| pass_o | output | 1 | 1 when the condition holds |
| op_a_i | input | DATA_W | First operand |
| op_b_i | input | DATA_W | Second operand |
| carry_i | input | 1 | Carry-in for addition |
| sub_i | input | 1 | 1 selects subtraction |
| res_o | output | DATA_W | Sum or difference |
| flags_o | output | 4 | Flags {N,Z,C,V} produced by the operation |

## Verification
The bench builds the unit with the default DATA_W of 32. At that width, carry-out from bit 32 and the signed overflow boundaries 0x7FFFFFFF and 0x80000000 can be reached with directed operands. The decoder is swept over all 16 codes against all 16 flag combinations. Random add and subtract operations follow, each checked at the ports. The bench also chains an operation's flags back into the decoder, so the signed and unsigned comparisons are exercised on flags that real arithmetic produced.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int NUM_CODES = 16;
  localparam int NUM_PAIRS = 7;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cc_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  logic [NUM_PAIRS-1:0] base;
  logic [NUM_CODES-1:0] pass_vec;

  // even code of each pair tests the predicate, odd code its inverse
  always_comb begin
    base[0] = flags_i.z;
    base[1] = flags_i.c;
    base[2] = flags_i.n;
    base[3] = flags_i.v;
    base[4] = flags_i.c & ~flags_i.z;
    base[5] = (flags_i.n == flags_i.v);
    base[6] = ~flags_i.z & (flags_i.n == flags_i.v);
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign pass_vec[2*k]   = base[k];
    assign pass_vec[2*k+1] = ~base[k];
  end

  assign pass_vec[NUM_CODES-2] = 1'b1;
  assign pass_vec[NUM_CODES-1] = 1'b0;

  assign pass_o = pass_vec[cond_i];
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  localparam int SUM_W = DATA_W + 1;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [SUM_W-1:0]  sum;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? 1'b1 : cin_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};

  assign res_o     = sum[MSB:0];
  assign flags_o.n = sum[MSB];
  assign flags_o.z = (sum[MSB:0] == '0);
  assign flags_o.c = sum[DATA_W];
  assign flags_o.v = (a_i[MSB] == b_eff[MSB]) & (sum[MSB] != a_i[MSB]);
endmodule

// File: rtl/cond_unit.sv
module cond_unit
  import cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  output logic              pass_o,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              carry_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic [3:0]        flags_o
);
  flags_t fl_in;
  flags_t fl_out;

  assign fl_in   = flags_t'(flags_i);
  assign flags_o = fl_out;

  cond_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (fl_in),
    .pass_o  (pass_o)
  );

  flag_gen #(.DATA_W(DATA_W)) u_fgen (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .cin_i   (carry_i),
    .sub_i   (sub_i),
    .res_o   (res_o),
    .flags_o (fl_out)
  );
endmodule

// File: rtl/cond_unit_chk.sv
module cond_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic [3:0]        cond_i,
  input logic [3:0]        flags_i,
  input logic              pass_o,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              carry_i,
  input logic              sub_i,
  input logic [DATA_W-1:0] res_o,
  input logic [3:0]        flags_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    if (cond_i == 4'd15) p_never_r5: assert (!pass_o);
    if (cond_i == 4'd14) p_always_r5: assert (pass_o);
    if (cond_i == 4'd0) p_zset_r1: assert (pass_o == flags_i[2]);
    if (cond_i == 4'd11) p_lt_r3: assert (pass_o == (flags_i[3] ^ flags_i[0]));
    p_zero_r7: assert (flags_o[2] == (res_o == '0));
    p_sign_r6: assert (flags_o[3] == res_o[MSB]);
    if (!sub_i && op_a_i[MSB] == op_b_i[MSB] && res_o[MSB] != op_a_i[MSB])
      p_ovf_r9: assert (flags_o[0]);
    if (!sub_i && op_a_i[MSB] != op_b_i[MSB])
      p_no_ovf_r9: assert (!flags_o[0]);
    if (sub_i && op_a_i == op_b_i)
      p_eq_sub_r8: assert (flags_o[1] && flags_o[2]);
  end
endmodule

bind cond_unit cond_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/cond_unit_tb_top.sv
module cond_unit_tb_top;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]    cond;
  logic [3:0]    flg;
  logic          pass;
  logic [DW-1:0] a, b, res;
  logic          cin, sub;
  logic [3:0]    fo;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  cond_unit #(.DATA_W(DW)) dut_i (
    .cond_i(cond), .flags_i(flg), .pass_o(pass),
    .op_a_i(a), .op_b_i(b), .carry_i(cin), .sub_i(sub),
    .res_o(res), .flags_o(fo)
  );

  function automatic logic exp_pass(logic [3:0] c, logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DW+3:0] exp_arith(logic [DW-1:0] x, logic [DW-1:0] y,
                                              logic ci, logic s);
    logic [DW:0] t;
    logic v;
    if (s) begin
      t = {1'b0, x} + {1'b0, ~y} + (DW+1)'(1);
      v = (x[DW-1] != y[DW-1]) && (t[DW-1] != x[DW-1]);
    end else begin
      t = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
      v = (x[DW-1] == y[DW-1]) && (t[DW-1] != x[DW-1]);
    end
    return {t[DW-1:0], t[DW-1], (t[DW-1:0] == 0), t[DW], v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [DW-1:0] x, input logic [DW-1:0] y,
                        input logic ci, input logic s, input string req);
    logic [DW+3:0] e;
    @(posedge clk);
    a = x; b = y; cin = ci; sub = s;
    @(negedge clk);
    e = exp_arith(x, y, ci, s);
    chk(res == e[DW+3:4], {req, " res R10"}, 64'(res), 64'(e[DW+3:4]));
    chk(fo == e[3:0], {req, " flags"}, 64'(fo), 64'(e[3:0]));
  endtask

  task automatic test_cond(input logic [3:0] c, input logic [3:0] f, input string req);
    @(posedge clk);
    cond = c; flg = f;
    @(negedge clk);
    chk(pass == exp_pass(c, f), req, 64'(pass), 64'(exp_pass(c, f)));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    cond = 0; flg = 0; a = 0; b = 0; cin = 0; sub = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // quiescent state: Z from zero sum, code 0 on clear flags fails
    chk(pass == 1'b0, "R1 idle pass", 64'(pass), 64'(0));
    chk(fo == 4'b0100, "R7 idle flags", 64'(fo), 64'(4'b0100));

    // R1 R2 R3 R4 R5 R6: every code on every flag combination
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        test_cond(4'(c), 4'(f), c < 8 ? "R1/R6" : c < 10 ? "R2" :
                  c < 12 ? "R3" : c < 14 ? "R4" : "R5");

    // directed arithmetic corners
    run_op(32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, "R7 carry out zero");
    run_op(32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, "R9 pos overflow");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R9 neg overflow");
    run_op(32'h0, 32'h0, 1'b1, 1'b0, "R7 carry in");
    run_op(32'h5, 32'h5, 1'b0, 1'b1, "R8 equal sub");
    run_op(32'h3, 32'h5, 1'b1, 1'b1, "R8 borrow, carry ignored");
    run_op(32'h8000_0000, 32'h1, 1'b0, 1'b1, "R9 sub overflow");

    // chained: flags of 3-5 fed back, signed LT and unsigned lower
    @(posedge clk);
    a = 32'h3; b = 32'h5; sub = 1'b1;
    @(negedge clk);
    flg = fo;
    cond = 4'd11;
    @(negedge clk);
    chk(pass == 1'b1, "R3 chained 3<5 signed", 64'(pass), 64'(1));
    cond = 4'd3;
    @(negedge clk);
    chk(pass == 1'b1, "R1 chained 3<5 unsigned", 64'(pass), 64'(1));
    cond = 4'd8;
    @(negedge clk);
    chk(pass == 1'b0, "R2 chained not higher", 64'(pass), 64'(0));

    // random operations
    for (int i = 0; i < 1500; i++) begin
      logic [DW-1:0] x, y;
      x = $urandom();
      y = ($urandom() % 4 == 0) ? x : $urandom();
      run_op(x, y, 1'($urandom()), 1'($urandom()), "R7/R8/R9 random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule